// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 262,144 words by 16 bits. The host issues one access at a time through a valid/ready handshake: an 18-bit word address, a write flag, 16 bits of write data and a two-bit lane mask. The controller turns each accepted request into a sequence of active-low chip-select, write-strobe, output-gate and per-byte lane-select signals. It returns read data through a one-cycle response pulse.

Every delay the memory needs is a whole number of clock cycles, set by parameters. These cover the read access wait, the width of the write strobe and the dead time before a write that follows a read. The strobes are ordered so that the controller drives the shared data bus only after the memory's own output drivers are off. The controller keeps driving the data, with address and lane selects unchanged, through the cycle in which the write strobe rises. The memory commits data on that edge.

Top module: `sram_ctrl`

## Requirements
- R1: During and right after synchronous reset, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: While no access is in progress (req_ready high), mem_ce_n is 1 and mem_dq_oe is 0.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for RD_CYC cycles. It samples mem_dq_in at the end of the last of those cycles. rsp_valid is 1 for exactly one cycle, RD_CYC cycles after acceptance, and carries that sample on rsp_rdata.
- R4: A write holds mem_ce_n=0 and mem_oe_n=1 throughout and drives mem_we_n=0 for exactly WR_CYC consecutive cycles. mem_dq_oe is 1 with mem_dq_out equal to the request data while mem_we_n is low and in the cycle in which it returns high, so the memory stores the data on that rising edge.
- R5: mem_dq_oe is never 1 while mem_oe_n is 0 or mem_ce_n is 1, and it only rises in a cycle where mem_we_n is already 0.
- R6: req_mask bit 0 enables data bits 7..0 through mem_lb_n, and bit 1 enables bits 15..8 through mem_ub_n. A lane select is 0 during an access exactly when its mask bit is 1, for both reads and writes, so a masked-off lane keeps its stored value on a write.
- R7: A write accepted after a read (no write in between) first spends TA_CYC cycles with every strobe at 1 and mem_dq_oe at 0, so it is busy for 2+WR_CYC+TA_CYC cycles. Other writes are busy for 2+WR_CYC cycles.
- R8: req_ready is 0 from the cycle after acceptance until the access completes. A req_valid presented while req_ready is 0 is ignored.
- R9: mem_addr, mem_lb_n and mem_ub_n stay unchanged for every cycle in which mem_ce_n stays 0 within one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| req_ready | output | 1 | Controller idle, request taken when valid |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Registered read data |
| mem_addr | output | 18 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output gate, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_in | input | 16 | Data returned by memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The bench builds the controller with RD_CYC=3, WR_CYC=2 and TA_CYC=2. Every wait counter therefore has to count through more than one value, and the read-to-write dead time is longer than a single cycle. With these values, an off-by-one in the read sample point, the strobe width or the turnaround length changes a measured busy time or a stored value. A behavioural memory model commits data on the write strobe's rising edge and flags bus contention. This exposes any reordering of the bus-drive enable against the output gate.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_READ_WAIT  = 3'd1,
        ST_TURNAROUND = 3'd2,
        ST_WR_SETUP   = 3'd3,
        ST_WR_PULSE   = 3'd4,
        ST_WR_HOLD    = 3'd5
    } seq_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_sel.sv
module sram_lane_sel #(
    parameter int LANES = 2
) (
    input  logic             active,
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] sel_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign sel_n[i] = ~(active & mask[i]);
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 2,
    parameter int TA_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int LANES = DATA_W / 8;
    localparam int CNT_W = $clog2(max3(RD_CYC, WR_CYC, TA_CYC) + 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic              rd_last_q;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rdata_q;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_done;
    logic              accept;
    logic              in_access;
    logic [LANES-1:0]  lane_n;

    assign accept = req_valid && (state_q == ST_IDLE);

    sram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_done)
    );

    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                cnt_load = 1'b1;
                if (!req_write) begin
                    state_d = ST_READ_WAIT;
                    cnt_val = RD_LOAD;
                end else if (rd_last_q) begin
                    state_d = ST_TURNAROUND;
                    cnt_val = TA_LOAD;
                end else begin
                    state_d = ST_WR_SETUP;
                end
            end
            ST_READ_WAIT:  if (cnt_done) state_d = ST_IDLE;
            ST_TURNAROUND: if (cnt_done) state_d = ST_WR_SETUP;
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                cnt_load = 1'b1;
                cnt_val  = WR_LOAD;
            end
            ST_WR_PULSE:   if (cnt_done) state_d = ST_WR_HOLD;
            ST_WR_HOLD:    state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            wdata_q     <= '0;
            mask_q      <= '0;
            rd_last_q   <= 1'b0;
            rsp_valid_q <= 1'b0;
            rdata_q     <= '0;
        end else begin
            state_q     <= state_d;
            rsp_valid_q <= 1'b0;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
            end
            if (state_q == ST_READ_WAIT && cnt_done) begin
                rdata_q     <= mem_dq_in;
                rsp_valid_q <= 1'b1;
                rd_last_q   <= 1'b1;
            end
            if (state_q == ST_WR_SETUP)
                rd_last_q <= 1'b0;
        end
    end

    assign in_access = (state_q == ST_READ_WAIT) || (state_q == ST_WR_SETUP) ||
                       (state_q == ST_WR_PULSE)  || (state_q == ST_WR_HOLD);

    sram_lane_sel #(.LANES(LANES)) u_lanes (
        .active (in_access),
        .mask   (mask_q),
        .sel_n  (lane_n)
    );

    assign req_ready  = (state_q == ST_IDLE);
    assign rsp_valid  = rsp_valid_q;
    assign rsp_rdata  = rdata_q;
    assign mem_addr   = addr_q;
    assign mem_ce_n   = !in_access;
    assign mem_oe_n   = (state_q != ST_READ_WAIT);
    assign mem_we_n   = (state_q != ST_WR_PULSE);
    assign mem_dq_oe  = (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD);
    assign mem_dq_out = wdata_q;
    assign mem_lb_n   = lane_n[0];
    assign mem_ub_n   = lane_n[LANES-1];

    // R5: never fight the memory's output drivers
    a_r5_no_drive_while_gated: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

    // R5: drive begins only after the write strobe has gone low
    a_r5_drive_after_we_low: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> !mem_we_n);

    // R4: data still driven when the write strobe rises
    a_r4_data_through_we_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_we_n) && !mem_ce_n) |-> mem_dq_oe);

    // R9: address and lane selects frozen across an access
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));

    // R3: response pulse lasts one cycle
    a_r3_valid_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R8: an accepted request makes the controller busy next cycle
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;
    localparam int RD = 3;
    localparam int WR = 2;
    localparam int TA = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    int n_cmp = 0;
    int n_bad = 0;
    int we_run = 0;
    bit prev_rd = 1'b0;
    logic [15:0] mem [256];
    logic [15:0] shadow [256];

    always #2 clk = ~clk;

    sram_ctrl #(.RD_CYC(RD), .WR_CYC(WR), .TA_CYC(TA)) i_sram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // behavioural asynchronous memory
    always_comb begin
        mem_dq_in = 16'h0000;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (!mem_lb_n) mem_dq_in[7:0]  = mem[mem_addr[7:0]][7:0];
            if (!mem_ub_n) mem_dq_in[15:8] = mem[mem_addr[7:0]][15:8];
        end
    end

    always @(posedge mem_we_n) begin
        if (!rst && !mem_ce_n && mem_dq_oe) begin
            if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) mem[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // bus monitor: strobe width and contention
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe) check(mem_oe_n && !mem_ce_n, "R5 drive while gated", {mem_oe_n, mem_ce_n}, 2'b10);
            if (req_ready) check(mem_ce_n && !mem_dq_oe, "R2 idle strobes", {mem_ce_n, mem_dq_oe}, 2'b10);
            if (!mem_we_n) begin
                we_run++;
                check(mem_oe_n && mem_dq_oe, "R4 gate off, data driven", {mem_oe_n, mem_dq_oe}, 2'b11);
            end else if (we_run != 0) begin
                check(we_run == WR, "R4 strobe width", we_run, WR);
                check(mem_dq_oe, "R4 data held at strobe rise", mem_dq_oe, 1);
                we_run = 0;
            end
        end
    end

    task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        int n;
        int exp_busy;
        logic [15:0] lanes;
        lanes = {{8{m[1]}}, {8{m[0]}}};
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        exp_busy = wr ? (2 + WR + (prev_rd ? TA : 0)) : RD;
        n = 1;
        if (!wr || !prev_rd) begin
            check(mem_addr == a, "R9 address", mem_addr, a);
            check({mem_ub_n, mem_lb_n} == ~m, "R6 lane selects", {mem_ub_n, mem_lb_n}, ~m);
        end else begin
            check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R7 turnaround idle",
                  {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        end
        while (!req_ready && n < 64) begin
            @(negedge clk);
            if (!req_ready) n++;
        end
        check(n == exp_busy, wr ? "R7 write busy time" : "R8 read busy time", n, exp_busy);
        if (wr) begin
            shadow[a[7:0]] = (shadow[a[7:0]] & ~lanes) | (d & lanes);
        end else begin
            check(rsp_valid, "R3 response strobe", rsp_valid, 1);
            check((rsp_rdata & lanes) == (shadow[a[7:0]] & lanes), "R3/R6 read data",
                  rsp_rdata & lanes, shadow[a[7:0]] & lanes);
            @(negedge clk);
            check(!rsp_valid, "R3 single-cycle strobe", rsp_valid, 0);
        end
        prev_rd = !wr;
    endtask

    // op, address, data, mask
    localparam logic [36:0] VEC [10] = '{
        {1'b1, 18'h00010, 16'hA5C3, 2'b11},
        {1'b0, 18'h00010, 16'h0000, 2'b11},
        {1'b1, 18'h00010, 16'h7700, 2'b10},
        {1'b0, 18'h00010, 16'h0000, 2'b11},
        {1'b1, 18'h3FFFF, 16'h1234, 2'b01},
        {1'b0, 18'h3FFFF, 16'h0000, 2'b11},
        {1'b1, 18'h00020, 16'hBEEF, 2'b11},
        {1'b1, 18'h00021, 16'hCAFE, 2'b11},
        {1'b0, 18'h00021, 16'h0000, 2'b01},
        {1'b0, 18'h00020, 16'h0000, 2'b10}
    };

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'h0000;
            shadow[i] = 16'h0000;
        end
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
              "R1 strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 6'b111110);
        check(req_ready && !rsp_valid, "R1 handshake in reset", {req_ready, rsp_valid}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        check(mem_ce_n && !mem_dq_oe && req_ready, "R1 after reset", {mem_ce_n, mem_dq_oe, req_ready}, 3'b101);

        for (int i = 0; i < 10; i++)
            access(VEC[i][36], VEC[i][35:18], VEC[i][17:2], VEC[i][1:0]);

        // R8: a request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00021; req_mask = 2'b11;
        @(posedge clk);
        @(negedge clk);
        req_write = 1'b1; req_addr = 18'h00020; req_wdata = 16'h0000;
        check(!req_ready, "R8 busy after accept", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        prev_rd = 1'b1;
        access(1'b0, 18'h00020, 16'h0000, 2'b11);
        check(mem[8'h20] == 16'hBEEF, "R8 ignored write left memory", mem[8'h20], 16'hBEEF);

        // R6: masked-off upper lane survives a write
        access(1'b1, 18'h00040, 16'hFFFF, 2'b11);
        access(1'b1, 18'h00040, 16'h1111, 2'b01);
        check(mem[8'h40] == 16'hFF11, "R6 upper lane kept", mem[8'h40], 16'hFF11);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule